// File: doc/BRIEF.md
# Binary64 to binary16 narrowing converter

This unit narrows one IEEE-754 double-precision word to a half-precision word each cycle. A two-bit selector picks the rounding direction. Before rounding, the unit ORs the low 32 bits of the double mantissa into a single sticky bit. One rounding path, about as wide as a single-precision one, then gives the same result that direct rounding of the full 52-bit mantissa would give. NaN, infinity, overflow, half subnormals and very small inputs are each handled explicitly.

A second output flags when the half result stands for the input value exactly and is a normal half or zero. Callers use this flag to decide whether a constant can be stored in half precision without loss. The input side and the output side are each a data word with a valid bit. Outputs are registered one cycle after the input.

Top module: `dbl2half`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock edge. The result of a vector presented with `in_valid` high appears on the outputs after the next rising edge.
- R2: The `in_rmode` encoding is 0 = nearest-even, 1 = toward +inf, 2 = toward -inf, 3 = toward zero. In nearest-even mode an exact halfway case rounds to the neighbour whose last mantissa bit is 0.
- R3: The directed modes round the magnitude up whenever any discarded bit is set and the direction of the mode calls for it. Toward zero never rounds up.
- R4: Each of the low 32 bits of the double mantissa can change the result only by being nonzero. Setting any of them on an exact or halfway value moves the result exactly as a sticky bit does.
- R5: Any NaN input (exponent 0x7FF, mantissa nonzero) gives 0x7E00 with the input sign. An infinite input gives 0x7C00 with the input sign.
- R6: On overflow, nearest-even gives infinity and toward zero gives magnitude 0x7BFF. A directed mode gives infinity when it rounds away from zero for that sign, and 0x7BFF otherwise. The largest finite result, 0x7BFF, is 65504.
- R7: Results below 2^-14 are produced as correctly rounded half subnormals, and may round up to 0x0400.
- R8: An input whose exponent field is below 897 (too small to be a single-precision normal) gives signed zero in every mode.
- R9: Bit 15 of the result always equals bit 63 of the input, NaN included.
- R10: `out_exact` is 1 only when the result converts back to the input value exactly and is not a half subnormal. Zero and infinity count as exact. NaN, overflow and any lost bit do not.
- R11: While reset is asserted, `out_valid`, `out_half` and `out_exact` are 0.
- R12: A cycle with `in_valid` low leaves `out_half` and `out_exact` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_bits | input | 64 | Double-precision operand |
| in_rmode | input | 2 | Rounding direction select |
| out_valid | output | 1 | Registered result is valid |
| out_half | output | 16 | Half-precision result |
| out_exact | output | 1 | Result is exact and not a half subnormal |

## Verification
Every result is due exactly one rising edge after its vector. The bench drives a vector at a falling edge and samples the outputs at the following falling edge, halfway between that rising edge and the next one. Idle cycles are inserted with fresh data on `in_bits` and `in_valid` low. These are sampled at the same point, one edge later, to confirm that the held result has not moved.

// File: rtl/dbl2half.sv
module dbl2half (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_bits,
  input  logic [1:0]  in_rmode,
  output logic        out_valid,
  output logic [15:0] out_half,
  output logic        out_exact
);
  localparam logic [10:0] EXP_MAX   = 11'h7FF;
  localparam logic [10:0] EXP_TINY  = 11'd897;
  localparam logic [10:0] EXP_SUB   = 11'd1008;
  localparam logic [10:0] EXP_OVF   = 11'd1039;
  localparam logic [14:0] MAG_INF   = 15'h7C00;
  localparam logic [14:0] MAG_BIG   = 15'h7BFF;
  localparam logic [14:0] MAG_QNAN  = 15'h7E00;

  logic        sgn;
  logic [10:0] ex;
  logic [51:0] man;
  logic [19:0] mred;
  logic        is_nan, is_inf, is_tiny, is_ovf, is_sub, is_zero;
  logic [10:0] sub_dist;
  logic [5:0]  shamt;
  logic [52:0] aligned;
  logic [10:0] keep;
  logic        guard, sticky, bump;
  logic [4:0]  hexp;
  logic [14:0] mag, ovf_mag;
  logic [15:0] res;
  logic        exact;

  assign sgn  = in_bits[63];
  assign ex   = in_bits[62:52];
  assign man  = in_bits[51:0];
  assign mred = {man[51:33], man[32] | (|man[31:0])};

  assign is_nan  = (ex == EXP_MAX) && (man != '0);
  assign is_inf  = (ex == EXP_MAX) && (man == '0);
  assign is_tiny = ex < EXP_TINY;
  assign is_zero = (ex == '0) && (man == '0);
  assign is_ovf  = (ex != EXP_MAX) && (ex >= EXP_OVF);
  assign is_sub  = !is_tiny && (ex <= EXP_SUB);

  assign sub_dist = 11'd1009 - ex;
  assign shamt    = !is_sub ? 6'd0 : (sub_dist > 11'd32 ? 6'd32 : sub_dist[5:0]);
  assign aligned  = {1'b1, mred, 32'b0} >> shamt;
  assign keep     = aligned[52:42];
  assign guard    = aligned[41];
  assign sticky   = |aligned[40:0];

  always_comb begin
    unique case (in_rmode)
      2'd0:    bump = guard & (sticky | keep[0]);
      2'd1:    bump = !sgn & (guard | sticky);
      2'd2:    bump = sgn & (guard | sticky);
      default: bump = 1'b0;
    endcase
  end

  assign hexp    = is_sub ? 5'd0 : 5'(ex - EXP_SUB);
  assign mag     = {hexp, keep[9:0]} + 15'(bump);
  assign ovf_mag = (in_rmode == 2'd0 || (in_rmode == 2'd1 && !sgn) || (in_rmode == 2'd2 && sgn))
                   ? MAG_INF : MAG_BIG;

  always_comb begin
    if (is_nan)       res = {sgn, MAG_QNAN};
    else if (is_inf)  res = {sgn, MAG_INF};
    else if (is_tiny) res = {sgn, 15'd0};
    else if (is_ovf)  res = {sgn, ovf_mag};
    else              res = {sgn, mag};
  end

  assign exact = is_inf || is_zero ||
                 (!is_nan && !is_tiny && !is_ovf && !is_sub && !guard && !sticky);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_half  <= '0;
      out_exact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_half  <= res;
        out_exact <= exact;
      end
    end
  end
endmodule

module dbl2half_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_bits,
  input logic [1:0]  in_rmode,
  input logic        out_valid,
  input logic [15:0] out_half,
  input logic        out_exact
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    out_valid == $past(in_valid));

  p_sign_r9: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $past(in_valid) |-> out_half[15] == $past(in_bits[63]));

  p_nan_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(in_valid) && $past(in_bits[62:52]) == 11'h7FF && $past(in_bits[51:0]) != 52'd0)
    |-> out_half[14:0] == 15'h7E00);

  p_rz_no_inf_r6: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(in_valid) && $past(in_rmode) == 2'd3 && $past(in_bits[62:52]) != 11'h7FF)
    |-> out_half[14:0] != 15'h7C00);

  p_exact_not_denorm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_exact |-> !(out_half[14:0] != 15'd0 && out_half[14:0] <= 15'h03FF));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    !$past(in_valid) |-> ($stable(out_half) && $stable(out_exact)));

  always @(negedge clk)
    if (!rst_n) p_reset_r11: assert (!out_valid && out_half == 16'd0 && !out_exact);
endmodule

bind dbl2half dbl2half_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
  .in_rmode(in_rmode), .out_valid(out_valid), .out_half(out_half), .out_exact(out_exact)
);

// File: tb/tb_dbl2half.sv
module tb_dbl2half;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_bits = '0;
  logic [1:0]  in_rmode = '0;
  logic        out_valid;
  logic [15:0] out_half;
  logic        out_exact;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  dbl2half dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .in_rmode(in_rmode), .out_valid(out_valid), .out_half(out_half), .out_exact(out_exact)
  );

  function automatic logic [16:0] ref_conv(logic [63:0] d, logic [1:0] rm);
    logic s, up, ex;
    int e_unb, qexp, sh, eh;
    logic [255:0] sig, kept, rem, half;
    logic [14:0] m;
    s = d[63];
    if (d[62:52] == 11'h7FF) return (d[51:0] != 0) ? {1'b0, s, 15'h7E00} : {1'b1, s, 15'h7C00};
    if (d[62:52] < 11'd897) return {(d[62:0] == 63'd0), s, 15'h0};
    e_unb = int'(d[62:52]) - 1023;
    sig   = {203'b0, 1'b1, d[51:0]};
    qexp  = ((e_unb < -14) ? -14 : e_unb) - 10;
    sh    = qexp - (e_unb - 52);
    kept  = sig >> sh;
    rem   = sig - (kept << sh);
    half  = 256'd1 << (sh - 1);
    case (rm)
      2'd0: up = (rem > half) || (rem == half && kept[0]);
      2'd1: up = !s && rem != 0;
      2'd2: up = s && rem != 0;
      default: up = 1'b0;
    endcase
    ex = (rem == 0) && (kept >= 1024);
    kept = kept + 256'(up);
    if (kept < 1024) begin
      m = kept[14:0];
    end else begin
      eh = qexp + 25;
      if (kept == 2048) begin kept = 1024; eh = eh + 1; end
      if (eh >= 31) begin
        ex = 1'b0;
        m = (rm == 0 || (rm == 1 && !s) || (rm == 2 && s)) ? 15'h7C00 : 15'h7BFF;
      end else begin
        m = {eh[4:0], kept[9:0]};
      end
    end
    return {ex, s, m};
  endfunction

  task automatic check(string tag, logic [63:0] d, logic [1:0] rm, logic [15:0] exp_h, logic exp_x);
    n_tests++;
    if (out_valid !== 1'b1 || out_half !== exp_h || out_exact !== exp_x) begin
      n_fail++;
      $display("FAIL %s in=%h rm=%0d: got v=%b h=%h x=%b, expected v=1 h=%h x=%b",
               tag, d, rm, out_valid, out_half, out_exact, exp_h, exp_x);
    end
  endtask

  task automatic drive(logic [63:0] d, logic [1:0] rm);
    @(negedge clk);
    in_valid = 1'b1; in_bits = d; in_rmode = rm;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic directed(string tag, logic [63:0] d, logic [1:0] rm, logic [15:0] h, logic x);
    drive(d, rm);
    check(tag, d, rm, h, x);
  endtask

  task automatic hold_check(logic [15:0] h, logic x);
    in_bits = 64'h4000_0000_0000_0000; in_rmode = 2'd1;
    @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || out_half !== h || out_exact !== x) begin
      n_fail++;
      $display("FAIL R12 hold: got v=%b h=%h x=%b, expected v=0 h=%h x=%b",
               out_valid, out_half, out_exact, h, x);
    end
  endtask

  function automatic string tag_of(logic [63:0] d, logic [1:0] rm);
    if (d[62:52] == 11'h7FF) return "R5";
    if (d[62:52] < 11'd897)  return "R8";
    if (d[62:52] >= 11'd1039) return "R6";
    if (d[62:52] <= 11'd1008) return "R7";
    return (rm == 2'd0) ? "R2" : "R3";
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [1:0]  rm;
    logic [16:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || out_half !== 16'h0 || out_exact !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset: got v=%b h=%h x=%b, expected v=0 h=0000 x=0", out_valid, out_half, out_exact);
    end
    rst_n = 1'b1;

    directed("R1 one", 64'h3FF0_0000_0000_0000, 2'd0, 16'h3C00, 1'b1);
    hold_check(16'h3C00, 1'b1);
    directed("R2 tie even down", 64'h3FF0_0200_0000_0000, 2'd0, 16'h3C00, 1'b0);
    directed("R2 tie odd up",    64'h3FF0_0600_0000_0000, 2'd0, 16'h3C02, 1'b0);
    directed("R4 tie plus low sticky", 64'h3FF0_0200_0000_0001, 2'd0, 16'h3C01, 1'b0);
    directed("R4 low sticky RU", 64'h3FF0_0000_0000_0001, 2'd1, 16'h3C01, 1'b0);
    directed("R3 low sticky RZ", 64'h3FF0_0000_0000_0001, 2'd3, 16'h3C00, 1'b0);
    directed("R3 neg RD", 64'hBFF0_0000_0000_0001, 2'd2, 16'hBC01, 1'b0);
    directed("R3 neg RU", 64'hBFF0_0000_0000_0001, 2'd1, 16'hBC00, 1'b0);
    directed("R6 max finite", 64'h40EF_FC00_0000_0000, 2'd0, 16'h7BFF, 1'b1);
    directed("R6 RNE overflow", 64'h40EF_FE00_0000_0000, 2'd0, 16'h7C00, 1'b0);
    directed("R6 RZ overflow", 64'h40EF_FE00_0000_0000, 2'd3, 16'h7BFF, 1'b0);
    directed("R6 RD pos big", 64'h412E_8480_0000_0000, 2'd2, 16'h7BFF, 1'b0);
    directed("R6 RU pos big", 64'h412E_8480_0000_0000, 2'd1, 16'h7C00, 1'b0);
    directed("R6 RU neg big", 64'hC12E_8480_0000_0000, 2'd1, 16'hFBFF, 1'b0);
    directed("R7 min subnormal", 64'h3E70_0000_0000_0000, 2'd0, 16'h0001, 1'b0);
    directed("R7 half min sub tie", 64'h3E60_0000_0000_0000, 2'd0, 16'h0000, 1'b0);
    directed("R7 half min sub RU", 64'h3E60_0000_0000_0000, 2'd1, 16'h0001, 1'b0);
    directed("R8 tiny RU", 64'h3370_0000_0000_0000, 2'd1, 16'h0000, 1'b0);
    directed("R8 tiny neg RD", 64'hB370_0000_0000_0000, 2'd2, 16'h8000, 1'b0);
    directed("R5 neg nan", 64'hFFF0_0000_0000_0001, 2'd0, 16'hFE00, 1'b0);
    directed("R5 neg inf", 64'hFFF0_0000_0000_0000, 2'd3, 16'hFC00, 1'b1);
    directed("R10 neg zero", 64'h8000_0000_0000_0000, 2'd0, 16'h8000, 1'b1);
    hold_check(16'h8000, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      logic [10:0] e;
      logic [51:0] m;
      int kind;
      kind = int'($urandom % 16);
      m = {$urandom, $urandom};
      if ((kind & 3) == 1) m[31:0] = '0;
      if ((kind & 3) == 2) m[40:0] = {40'd0, m[0]};
      if (kind == 15)      e = 11'h7FF;
      else if (kind == 14) e = 11'($urandom % 897);
      else                 e = 11'(870 + ($urandom % 190));
      d  = {1'($urandom), e, m};
      rm = 2'($urandom);
      r  = ref_conv(d, rm);
      drive(d, rm);
      check(tag_of(d, rm), d, rm, r[15:0], r[16]);
      if ((i % 97) == 0) hold_check(r[15:0], r[16]);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule